// File: doc/BRIEF.md
# Bridge-Mediated I2C Byte Access Sequencer

This block performs a single byte read or byte write to a hot-plug controller that sits on an I2C segment. It does not drive the I2C wires itself. It programs a memory-mapped bridge through a 32-bit register-bus master port, and the bridge carries out the I2C transfer. A request carries the direction, the controller type, the device address, a register index and, for writes, the data byte.

For each request the block builds a command word in one of two layouts. The addressed layout carries the device address and the index, and the direct layout carries the index only. The block then stores the command word, the message buffer word and a start bit to the bridge. It polls the bridge until the start bit drops and the status register shows no error or busy bits. For a read it then fetches the buffer. Every bus word crosses the port with its four bytes reversed.

Each poll loop is bounded. A read stops at the first timeout. A write that times out waiting for the start bit still goes through the status poll. Completion is a one-cycle `done_o` pulse. At that pulse the `err_o` flag and the read byte are valid.

Top module: `i2cseq_top`

## Requirements
- R1: With controller type 2 (addressed) the command word is 0x00010000 for a read or 0x40010000 for a write, ORed with the device address shifted right by one in bits 15:8 and the register index in bits 7:0.
- R2: With controller type 4 (direct) the command word is 0x10010000 for a read or 0x60010000 for a write, ORed with the register index in bits 15:8.
- R3: An accepted valid request first writes the command word to 0x0010. It then writes the buffer word to 0x0008: zero for a read, the data byte in bits 7:0 for a write. Third, it writes 0x00000002 to 0x2020, the OR-store alias of the control register at 0x0020.
- R4: Every word written is byte-reversed (bits 7:0 go to bits 31:24, and so on). Every word read is byte-reversed before it is examined.
- R5: After the start store, the block reads 0x0020 until bit 1 is clear. It then reads 0x0070 until no bit of mask 0x00000A76 is set. Every poll read is preceded by WAIT_CYC idle cycles.
- R6: Each poll loop makes at most MAX_TRIES reads. A loop that uses them all without success is a timeout.
- R7: On a read, a timeout in either loop ends the operation with `err_o` = 1 and no further bus access. A successful read fetches 0x0008 and returns the low byte of the reversed word on `rdata_o`, with `err_o` = 0.
- R8: On a write, a timeout in the control poll sets `err_o` and the status poll still runs. A write makes no read of 0x0008.
- R9: A request with a controller type other than 2 or 4 completes with `err_o` = 1 and makes no bus access.
- R10: The bus port has at most one access outstanding. While `bus_valid_o` is high without `bus_ready_i`, the address, direction and write data stay unchanged.
- R11: `done_o` is a single-cycle pulse per accepted request. A request presented while an operation is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request strobe, taken only when idle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| ctl_type_i | input | 8 | Controller type: 2 addressed, 4 direct |
| dev_addr_i | input | 8 | I2C device address (bit 0 dropped) |
| index_i | input | 8 | Register index in the controller |
| wdata_i | input | 8 | Byte to write |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Error flag, valid with done_o |
| rdata_o | output | 8 | Read byte, valid with done_o on a read |
| bus_valid_o | output | 1 | Bus access request |
| bus_ready_i | input | 1 | Bus access accepted and completed |
| bus_we_o | output | 1 | Bus access is a write |
| bus_addr_o | output | 16 | Bus byte offset |
| bus_wdata_o | output | 32 | Bus write data (byte-reversed) |
| bus_rdata_i | input | 32 | Bus read data (byte-reversed), valid with bus_ready_i |

## Verification
Several properties are checked on every cycle. The bus request stays stable while it is stalled, and writes go only to the three legal offsets. The start store always carries the reversed start bit, the per-loop read counts never exceed MAX_TRIES, and the done pulse never coincides with bus activity or lasts two cycles. The command word layouts, the exact store order, the byte reversal of read data, and the different timeout paths for reads and writes all depend on what the bridge returns. Only the directed scenarios against a responding bridge model can show those, by comparing the logged transaction list with the expected one.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;
  localparam logic [15:0] OFF_SETUP  = 16'h0010;
  localparam logic [15:0] OFF_BUF    = 16'h0008;
  localparam logic [15:0] OFF_CTL    = 16'h0020;
  localparam logic [15:0] OFF_CTL_OR = 16'h2020;
  localparam logic [15:0] OFF_STAT   = 16'h0070;

  localparam logic [31:0] START_BIT  = 32'h0000_0002;
  localparam logic [31:0] STAT_MASK  = 32'h0000_0A76;

  localparam logic [31:0] ADR_RD_BASE = 32'h0001_0000;
  localparam logic [31:0] ADR_WR_BASE = 32'h4001_0000;
  localparam logic [31:0] DIR_RD_BASE = 32'h1001_0000;
  localparam logic [31:0] DIR_WR_BASE = 32'h6001_0000;

  localparam logic [7:0] TYPE_ADDRESSED = 8'd2;
  localparam logic [7:0] TYPE_DIRECT    = 8'd4;

  typedef enum logic [3:0] {
    ST_IDLE, ST_SETUP, ST_BUFW, ST_START,
    ST_CTL_WAIT, ST_CTL_RD, ST_STAT_WAIT, ST_STAT_RD,
    ST_BUF_RD, ST_DONE
  } seq_state_e;

  function automatic logic [31:0] byte_rev(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction
endpackage

// File: rtl/i2cseq_word_build.sv
module i2cseq_word_build
  import i2cseq_pkg::*;
(
  input  logic        write_i,
  input  logic [7:0]  ctl_type_i,
  input  logic [7:0]  dev_addr_i,
  input  logic [7:0]  index_i,
  input  logic [7:0]  wdata_i,
  output logic [31:0] setup_o,
  output logic [31:0] buf_o,
  output logic        type_ok_o
);
  logic [7:0] dev_shift;
  assign dev_shift = {1'b0, dev_addr_i[7:1]};

  always_comb begin
    setup_o   = '0;
    type_ok_o = 1'b1;
    unique case (ctl_type_i)
      TYPE_ADDRESSED: setup_o = (write_i ? ADR_WR_BASE : ADR_RD_BASE)
                                | {16'h0, dev_shift, index_i};
      TYPE_DIRECT:    setup_o = (write_i ? DIR_WR_BASE : DIR_RD_BASE)
                                | {16'h0, index_i, 8'h00};
      default:        type_ok_o = 1'b0;
    endcase
  end

  assign buf_o = write_i ? {24'h0, wdata_i} : 32'h0;
endmodule

// File: rtl/i2cseq_poll_ctr.sv
module i2cseq_poll_ctr #(
  parameter int unsigned WAIT_CYC  = 500000,
  parameter int unsigned MAX_TRIES = 60
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic wait_en_i,
  input  logic fail_i,
  output logic wait_done_o,
  output logic last_try_o
);
  localparam int unsigned WAIT_W = $clog2(WAIT_CYC + 1);
  localparam int unsigned TRY_W  = $clog2(MAX_TRIES + 1);
  localparam logic [WAIT_W-1:0] WAIT_LAST = WAIT_W'(WAIT_CYC - 1);
  localparam logic [TRY_W-1:0]  TRY_LAST  = TRY_W'(MAX_TRIES - 1);

  logic [WAIT_W-1:0] wait_q;
  logic [TRY_W-1:0]  tries_q;

  assign wait_done_o = wait_en_i && (wait_q == WAIT_LAST);
  assign last_try_o  = (tries_q == TRY_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wait_q <= '0;
    end else if (restart_i || wait_done_o) begin
      wait_q <= '0;
    end else if (wait_en_i) begin
      wait_q <= wait_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tries_q <= '0;
    end else if (restart_i) begin
      tries_q <= '0;
    end else if (fail_i) begin
      tries_q <= tries_q + 1'b1;
    end
  end
endmodule

// File: rtl/i2cseq_top.sv
module i2cseq_top
  import i2cseq_pkg::*;
#(
  parameter int unsigned WAIT_CYC  = 500000,
  parameter int unsigned MAX_TRIES = 60
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  input  logic        req_write_i,
  input  logic [7:0]  ctl_type_i,
  input  logic [7:0]  dev_addr_i,
  input  logic [7:0]  index_i,
  input  logic [7:0]  wdata_i,
  output logic        done_o,
  output logic        err_o,
  output logic [7:0]  rdata_o,
  output logic        bus_valid_o,
  input  logic        bus_ready_i,
  output logic        bus_we_o,
  output logic [15:0] bus_addr_o,
  output logic [31:0] bus_wdata_o,
  input  logic [31:0] bus_rdata_i
);
  seq_state_e  state_q, state_d;
  logic        write_q;
  logic [31:0] setup_q, buf_q;
  logic        err_q;
  logic [7:0]  rdata_q;

  logic [31:0] setup_w, buf_w;
  logic        type_ok;
  logic        xfer, rd_ok, poll_fail, restart, wait_en, wait_done, last_try;
  logic        set_err;
  logic [31:0] rword;

  i2cseq_word_build i_build (
    .write_i   (req_write_i),
    .ctl_type_i(ctl_type_i),
    .dev_addr_i(dev_addr_i),
    .index_i   (index_i),
    .wdata_i   (wdata_i),
    .setup_o   (setup_w),
    .buf_o     (buf_w),
    .type_ok_o (type_ok)
  );

  i2cseq_poll_ctr #(
    .WAIT_CYC (WAIT_CYC),
    .MAX_TRIES(MAX_TRIES)
  ) i_poll (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .restart_i  (restart),
    .wait_en_i  (wait_en),
    .fail_i     (poll_fail),
    .wait_done_o(wait_done),
    .last_try_o (last_try)
  );

  // Bus request decode
  always_comb begin
    bus_valid_o = 1'b1;
    bus_we_o    = 1'b0;
    bus_addr_o  = '0;
    bus_wdata_o = '0;
    unique case (state_q)
      ST_SETUP:   begin bus_we_o = 1'b1; bus_addr_o = OFF_SETUP;  bus_wdata_o = byte_rev(setup_q); end
      ST_BUFW:    begin bus_we_o = 1'b1; bus_addr_o = OFF_BUF;    bus_wdata_o = byte_rev(buf_q); end
      ST_START:   begin bus_we_o = 1'b1; bus_addr_o = OFF_CTL_OR; bus_wdata_o = byte_rev(START_BIT); end
      ST_CTL_RD:  bus_addr_o = OFF_CTL;
      ST_STAT_RD: bus_addr_o = OFF_STAT;
      ST_BUF_RD:  bus_addr_o = OFF_BUF;
      default:    bus_valid_o = 1'b0;
    endcase
  end

  assign xfer  = bus_valid_o && bus_ready_i;
  assign rword = byte_rev(bus_rdata_i);
  assign rd_ok = (state_q == ST_CTL_RD) ? ((rword & START_BIT) == '0)
                                        : ((rword & STAT_MASK) == '0);
  assign wait_en = (state_q == ST_CTL_WAIT) || (state_q == ST_STAT_WAIT);

  always_comb begin
    state_d   = state_q;
    restart   = 1'b0;
    poll_fail = 1'b0;
    set_err   = 1'b0;
    unique case (state_q)
      ST_IDLE:
        if (req_valid_i) begin
          state_d = type_ok ? ST_SETUP : ST_DONE;
          set_err = !type_ok;
        end
      ST_SETUP: if (xfer) state_d = ST_BUFW;
      ST_BUFW:  if (xfer) state_d = ST_START;
      ST_START:
        if (xfer) begin
          state_d = ST_CTL_WAIT;
          restart = 1'b1;
        end
      ST_CTL_WAIT: if (wait_done) state_d = ST_CTL_RD;
      ST_CTL_RD:
        if (xfer) begin
          if (rd_ok) begin
            state_d = ST_STAT_WAIT;
            restart = 1'b1;
          end else if (last_try) begin
            set_err = 1'b1;
            // Writes still run the status poll after a control timeout
            state_d = write_q ? ST_STAT_WAIT : ST_DONE;
            restart = 1'b1;
          end else begin
            state_d   = ST_CTL_WAIT;
            poll_fail = 1'b1;
          end
        end
      ST_STAT_WAIT: if (wait_done) state_d = ST_STAT_RD;
      ST_STAT_RD:
        if (xfer) begin
          if (rd_ok) begin
            state_d = write_q ? ST_DONE : ST_BUF_RD;
          end else if (last_try) begin
            set_err = 1'b1;
            state_d = ST_DONE;
          end else begin
            state_d   = ST_STAT_WAIT;
            poll_fail = 1'b1;
          end
        end
      ST_BUF_RD: if (xfer) state_d = ST_DONE;
      ST_DONE:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      write_q <= 1'b0;
      setup_q <= '0;
      buf_q   <= '0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && req_valid_i) begin
        write_q <= req_write_i;
        setup_q <= setup_w;
        buf_q   <= buf_w;
        err_q   <= set_err;
        rdata_q <= '0;
      end else if (set_err) begin
        err_q <= 1'b1;
      end
      if (state_q == ST_BUF_RD && xfer) rdata_q <= rword[7:0];
    end
  end

  assign done_o  = (state_q == ST_DONE);
  assign err_o   = err_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/i2cseq_chk.sv
module i2cseq_chk #(
  parameter int unsigned MAX_TRIES = 60
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        done_o,
  input logic        bus_valid_o,
  input logic        bus_ready_i,
  input logic        bus_we_o,
  input logic [15:0] bus_addr_o,
  input logic [31:0] bus_wdata_o
);
  logic [31:0] ctl_rd_cnt, stat_rd_cnt;
  logic        hs, start_hs;

  assign hs       = bus_valid_o && bus_ready_i;
  assign start_hs = hs && bus_we_o && (bus_addr_o == 16'h2020);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_rd_cnt  <= '0;
      stat_rd_cnt <= '0;
    end else if (start_hs) begin
      ctl_rd_cnt  <= '0;
      stat_rd_cnt <= '0;
    end else if (hs && !bus_we_o) begin
      if (bus_addr_o == 16'h0020) ctl_rd_cnt  <= ctl_rd_cnt + 1;
      if (bus_addr_o == 16'h0070) stat_rd_cnt <= stat_rd_cnt + 1;
    end
  end

  // R10
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_o && !bus_ready_i) |=>
      (bus_valid_o && $stable(bus_addr_o) && $stable(bus_we_o) && $stable(bus_wdata_o)));

  // R3
  legal_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_o && bus_we_o) |->
      (bus_addr_o == 16'h0010 || bus_addr_o == 16'h0008 || bus_addr_o == 16'h2020));

  // R4
  start_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_o && bus_we_o && bus_addr_o == 16'h2020) |-> (bus_wdata_o == 32'h0200_0000));

  // R5
  legal_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_o && !bus_we_o) |->
      (bus_addr_o == 16'h0020 || bus_addr_o == 16'h0070 || bus_addr_o == 16'h0008));

  // R6
  ctl_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_rd_cnt <= MAX_TRIES);

  // R6
  stat_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_rd_cnt <= MAX_TRIES);

  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R11
  done_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !bus_valid_o);
endmodule

bind i2cseq_top i2cseq_chk #(.MAX_TRIES(MAX_TRIES)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .done_o     (done_o),
  .bus_valid_o(bus_valid_o),
  .bus_ready_i(bus_ready_i),
  .bus_we_o   (bus_we_o),
  .bus_addr_o (bus_addr_o),
  .bus_wdata_o(bus_wdata_o)
);

// File: tb/test_i2cseq_top.sv
module test_i2cseq_top;
  localparam int WAITC = 3;
  localparam int TRIES = 60;
  localparam int LOGN  = 512;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]  ctl_type = 8'd0, dev_addr = 8'd0, index = 8'd0, wdata = 8'd0;
  logic        done, err;
  logic [7:0]  rdata;
  logic        bus_valid, bus_ready, bus_we;
  logic [15:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;

  always #10 clk = ~clk;

  i2cseq_top #(.WAIT_CYC(WAITC), .MAX_TRIES(TRIES)) i_i2cseq_top (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_write_i(req_write), .ctl_type_i(ctl_type),
    .dev_addr_i(dev_addr), .index_i(index), .wdata_i(wdata),
    .done_o(done), .err_o(err), .rdata_o(rdata),
    .bus_valid_o(bus_valid), .bus_ready_i(bus_ready), .bus_we_o(bus_we),
    .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata), .bus_rdata_i(bus_rdata)
  );

  function automatic logic [31:0] rev(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  // Bridge model configuration (written by tasks)
  int          ctl_busy = 0, stat_busy = 0;
  logic [31:0] buf_val = 32'h0;

  // Bridge model state and transaction log (written by the responder)
  logic        rdy_en = 1'b0;
  logic [31:0] rdata_r = 32'h0;
  int          ctl_seen = 0, stat_seen = 0, n_log = 0, done_cnt = 0, cyc = 0;
  logic        log_we   [LOGN];
  logic [15:0] log_addr [LOGN];
  logic [31:0] log_data [LOGN];
  int          log_cyc  [LOGN];

  assign bus_ready = bus_valid & rdy_en;
  assign bus_rdata = rdata_r;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (done) done_cnt = done_cnt + 1;
    rdy_en = ~rdy_en;
    if (bus_valid && rdy_en) begin
      if (n_log < LOGN) begin
        log_we[n_log]   = bus_we;
        log_addr[n_log] = bus_addr;
        log_data[n_log] = bus_wdata;
        log_cyc[n_log]  = cyc;
      end
      n_log = n_log + 1;
      if (bus_we && bus_addr == 16'h2020) begin
        ctl_seen = 0;
        stat_seen = 0;
      end else if (!bus_we && bus_addr == 16'h0020) begin
        rdata_r = rev(ctl_seen < ctl_busy ? 32'h0000_0002 : 32'hFFFF_FFFD);
        ctl_seen = ctl_seen + 1;
      end else if (!bus_we && bus_addr == 16'h0070) begin
        rdata_r = rev(stat_seen < stat_busy ? 32'h0000_0800 : 32'hFFFF_F589);
        stat_seen = stat_seen + 1;
      end else if (!bus_we && bus_addr == 16'h0008) begin
        rdata_r = rev(buf_val);
      end
    end
  end

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  int          base;
  logic        got_err;
  logic [7:0]  got_rd;

  task automatic run_op(input logic w, input logic [7:0] t, input logic [7:0] d,
                        input logic [7:0] ix, input logic [7:0] wd);
    int n;
    @(negedge clk);
    base = n_log;
    req_write = w; ctl_type = t; dev_addr = d; index = ix; wdata = wd;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(done, "R11 done seen", {31'b0, done}, 32'h1);
    got_err = err;
    got_rd  = rdata;
    @(negedge clk);
  endtask

  task automatic chk_entry(input int i, input logic we, input logic [15:0] a,
                           input logic [31:0] dat, input string tag);
    chk(log_we[base+i] == we && log_addr[base+i] == a, tag, {15'b0, log_we[base+i], log_addr[base+i]},
        {15'b0, we, a});
    if (we) chk(log_data[base+i] == dat, tag, log_data[base+i], dat);
  endtask

  task automatic t_reset;
    chk(!done && !err && !bus_valid, "R11 reset idle", {29'b0, done, err, bus_valid}, 32'h0);
  endtask

  // R1 R3 R4 R5 R7: addressed read with busy polls
  task automatic t_read_addr;
    ctl_busy = 2; stat_busy = 3; buf_val = 32'h1234_56A5;
    run_op(1'b0, 8'd2, 8'hA4, 8'h1B, 8'h00);
    chk(n_log - base == 11, "R5 access count", n_log - base, 11);
    chk_entry(0, 1'b1, 16'h0010, 32'h1B52_0100, "R1 addressed read setup");
    chk_entry(1, 1'b1, 16'h0008, 32'h0000_0000, "R3 read buffer clear");
    chk_entry(2, 1'b1, 16'h2020, 32'h0200_0000, "R3 start store");
    for (int i = 3; i < 6; i++) chk_entry(i, 1'b0, 16'h0020, 0, "R5 control poll");
    for (int i = 6; i < 10; i++) chk_entry(i, 1'b0, 16'h0070, 0, "R5 status poll");
    chk_entry(10, 1'b0, 16'h0008, 0, "R7 buffer fetch");
    for (int i = 4; i < 10; i++)
      chk(log_cyc[base+i] - log_cyc[base+i-1] >= WAITC + 1, "R5 poll spacing",
          log_cyc[base+i] - log_cyc[base+i-1], WAITC + 1);
    chk(got_rd == 8'hA5 && !got_err, "R4 R7 read byte", {23'b0, got_err, got_rd}, 32'hA5);
  endtask

  // R2 R8: direct write, no buffer fetch
  task automatic t_write_direct;
    ctl_busy = 0; stat_busy = 0;
    run_op(1'b1, 8'd4, 8'hFF, 8'h33, 8'h5C);
    chk(n_log - base == 5, "R8 write access count", n_log - base, 5);
    chk_entry(0, 1'b1, 16'h0010, 32'h0033_0160, "R2 direct write setup");
    chk_entry(1, 1'b1, 16'h0008, 32'h5C00_0000, "R3 R4 write buffer byte");
    chk_entry(2, 1'b1, 16'h2020, 32'h0200_0000, "R3 start store");
    chk(!got_err, "R8 write ok", {31'b0, got_err}, 0);
  endtask

  task automatic t_read_direct;
    ctl_busy = 1; stat_busy = 0; buf_val = 32'hFFFF_FF3C;
    run_op(1'b0, 8'd4, 8'h00, 8'h07, 8'h00);
    chk_entry(0, 1'b1, 16'h0010, 32'h0007_0110, "R2 direct read setup");
    chk(got_rd == 8'h3C && !got_err, "R7 direct read byte", {23'b0, got_err, got_rd}, 32'h3C);
  endtask

  task automatic t_write_addr;
    ctl_busy = 0; stat_busy = 2;
    run_op(1'b1, 8'd2, 8'h41, 8'h05, 8'h99);
    chk_entry(0, 1'b1, 16'h0010, 32'h0520_0140, "R1 addressed write setup");
    chk(n_log - base == 7 && !got_err, "R8 write count", n_log - base, 7);
  endtask

  task automatic t_read_ctl_to;
    ctl_busy = 1000; stat_busy = 0;
    run_op(1'b0, 8'd2, 8'h10, 8'h01, 8'h00);
    chk(n_log - base == 3 + TRIES, "R6 R7 read control timeout count", n_log - base, 3 + TRIES);
    chk_entry(3 + TRIES - 1, 1'b0, 16'h0020, 0, "R6 last control read");
    chk(got_err, "R7 read control timeout err", {31'b0, got_err}, 1);
  endtask

  task automatic t_read_stat_to;
    ctl_busy = 0; stat_busy = 1000;
    run_op(1'b0, 8'd4, 8'h00, 8'h02, 8'h00);
    chk(n_log - base == 4 + TRIES, "R6 R7 read status timeout count", n_log - base, 4 + TRIES);
    chk(got_err, "R7 read status timeout err", {31'b0, got_err}, 1);
  endtask

  task automatic t_write_ctl_to;
    ctl_busy = 1000; stat_busy = 1;
    run_op(1'b1, 8'd2, 8'h20, 8'h03, 8'h11);
    chk(n_log - base == 5 + TRIES, "R8 status poll after control timeout", n_log - base, 5 + TRIES);
    chk_entry(3 + TRIES, 1'b0, 16'h0070, 0, "R8 status after timeout");
    chk(got_err, "R8 write control timeout err", {31'b0, got_err}, 1);
  endtask

  task automatic t_write_stat_to;
    ctl_busy = 0; stat_busy = 1000;
    run_op(1'b1, 8'd4, 8'h00, 8'h04, 8'h22);
    chk(n_log - base == 4 + TRIES, "R6 write status timeout count", n_log - base, 4 + TRIES);
    chk(got_err, "R6 write status timeout err", {31'b0, got_err}, 1);
  endtask

  task automatic t_bad_type;
    run_op(1'b0, 8'd3, 8'h00, 8'h01, 8'h00);
    chk(n_log == base, "R9 no bus access", n_log - base, 0);
    chk(got_err, "R9 bad type err", {31'b0, got_err}, 1);
  endtask

  task automatic t_ignore_busy;
    int d0;
    ctl_busy = 4; stat_busy = 0; buf_val = 32'h0000_0077;
    d0 = done_cnt;
    @(negedge clk);
    base = n_log;
    req_write = 1'b0; ctl_type = 8'd2; dev_addr = 8'h60; index = 8'h09;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (6) @(negedge clk);
    req_write = 1'b1; ctl_type = 8'd4; index = 8'h0E;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (200) @(negedge clk);
    chk(done_cnt - d0 == 1, "R11 one done pulse", done_cnt - d0, 1);
    chk(n_log - base == 3 + 5 + 1 + 1, "R11 request during op ignored", n_log - base, 10);
    chk_entry(0, 1'b1, 16'h0010, 32'h0930_0100, "R11 first op setup kept");
    chk(rdata == 8'h77 && !err, "R11 first op result", {23'b0, err, rdata}, 32'h77);
  endtask

  initial begin
    #(20 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual=%0d expected=finish", cyc);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_read_addr();
    t_write_direct();
    t_read_direct();
    t_write_addr();
    t_read_ctl_to();
    t_read_stat_to();
    t_write_ctl_to();
    t_write_stat_to();
    t_bad_type();
    t_ignore_busy();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule